// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

The block adds two 8-bit operands and a carry-in. Every bit position forms its own propagate (XOR of the operand bits) and generate (AND of the operand bits). Two 4-bit lookahead groups turn these into the carries inside each nibble. Every carry is a flat sum of products of the group's propagate, generate and carry-in terms, so no carry is built from another carry. Each group also gives a group-propagate and a group-generate that sum up its four positions. These two pairs feed a separate block-level lookahead unit. That unit makes the carry into the upper nibble and the final carry-out, so no carry ripples from one nibble to the next.

The sum, the carry-out and the carry into the most significant bit leave the block through one output register stage. A synchronous active-high reset clears that stage. A result appears on the clock edge after its operands were sampled. The carry into the top bit is a separate output so that a downstream unit can detect signed overflow by XOR with the carry-out.

Top module: `cla2_adder`

## Requirements
- R1: While `rst` is high at a rising clock edge, `sum_o`, `cout_o` and `c_msb_o` become zero, whatever the operand inputs are.
- R2: The outputs present at a rising edge reflect the operands sampled at that edge. This is a latency of exactly one clock.
- R3: `{cout_o, sum_o}` equals the 9-bit value `a_i + b_i + cin_i` for every one of the 2^17 input combinations.
- R4: When the lower nibble is fully propagating (`a_i[3:0] ^ b_i[3:0] == 4'hF`), the carry into bit 4 equals `cin_i`. At the ports this shows as `sum_o[4] == a_i[4] ^ b_i[4] ^ cin_i`.
- R5: When the lower nibble generates a carry on its own (`a_i[3:0] + b_i[3:0] >= 16`), the carry into bit 4 is 1 for either value of `cin_i`. This shows as `sum_o[4] == a_i[4] ^ b_i[4] ^ 1`.
- R6: `c_msb_o` is the carry into bit 7, that is bit 7 of `a_i[6:0] + b_i[6:0] + cin_i`.
- R7: A carry travels through all eight positions when every position propagates. For example, `a_i = 8'hFF`, `b_i = 8'h00`, `cin_i = 1` gives `sum_o = 8'h00`, `cout_o = 1`, `c_msb_o = 1`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 8 | Registered sum |
| cout_o | output | 1 | Registered carry out of bit 7 |
| c_msb_o | output | 1 | Registered carry into bit 7 |

## Verification
The bench builds the adder with its default shape: two groups of four bits. At this size the whole operand space is 2^17 combinations, and the bench drives every one of them, one per clock. Each result is compared against a plain behavioural sum. So every pattern of propagate and generate inside a nibble is reached, and so is every mix of the two group pairs at the block-level unit, including the end-to-end propagate chain and both nibble-boundary cases.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DEF_GRP_W = 4;
  localparam int unsigned DEF_N_GRP = 2;
endpackage

// File: rtl/cla_pg.sv
module cla_pg #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] p,
  output logic [W-1:0] g
);
  assign p = a ^ b;
  assign g = a & b;
endmodule

// File: rtl/cla_group.sv
// Lookahead group: every carry is expanded into a flat sum of products.
module cla_group #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W-1:0] c,
  output logic         gp,
  output logic         gg
);
  always_comb begin
    logic cv;
    logic tv;
    for (int k = 0; k < W; k++) begin
      cv = cin;
      for (int m = 0; m < k; m++) cv = cv & p[m];
      for (int j = 0; j < k; j++) begin
        tv = g[j];
        for (int m = j + 1; m < k; m++) tv = tv & p[m];
        cv = cv | tv;
      end
      c[k] = cv;
    end
  end

  always_comb begin
    logic tv;
    gp = &p;
    gg = 1'b0;
    for (int j = 0; j < W; j++) begin
      tv = g[j];
      for (int m = j + 1; m < W; m++) tv = tv & p[m];
      gg = gg | tv;
    end
  end
endmodule

// File: rtl/cla_block.sv
// Block-level lookahead over group propagate/generate pairs.
module cla_block #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] gp,
  input  logic [N-1:0] gg,
  input  logic         cin,
  output logic [N:0]   gc
);
  always_comb begin
    logic cv;
    logic tv;
    for (int k = 0; k <= N; k++) begin
      cv = cin;
      for (int m = 0; m < k; m++) cv = cv & gp[m];
      for (int j = 0; j < k; j++) begin
        tv = gg[j];
        for (int m = j + 1; m < k; m++) tv = tv & gp[m];
        cv = cv | tv;
      end
      gc[k] = cv;
    end
  end
endmodule

// File: rtl/cla2_adder.sv
module cla2_adder #(
  parameter int unsigned GRP_W = cla_pkg::DEF_GRP_W,
  parameter int unsigned N_GRP = cla_pkg::DEF_N_GRP
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [GRP_W*N_GRP-1:0]   a_i,
  input  logic [GRP_W*N_GRP-1:0]   b_i,
  input  logic                     cin_i,
  output logic [GRP_W*N_GRP-1:0]   sum_o,
  output logic                     cout_o,
  output logic                     c_msb_o
);
  localparam int unsigned DW = GRP_W * N_GRP;

  logic [DW-1:0]    p_w;
  logic [DW-1:0]    g_w;
  logic [DW-1:0]    cbit_w;
  logic [N_GRP-1:0] gp_w;
  logic [N_GRP-1:0] gg_w;
  logic [N_GRP:0]   gc_w;

  cla_pg #(.W(DW)) u_pg (.a(a_i), .b(b_i), .p(p_w), .g(g_w));

  for (genvar gi = 0; gi < N_GRP; gi++) begin : g_grp
    cla_group #(.W(GRP_W)) u_grp (
      .p   (p_w[gi*GRP_W +: GRP_W]),
      .g   (g_w[gi*GRP_W +: GRP_W]),
      .cin (gc_w[gi]),
      .c   (cbit_w[gi*GRP_W +: GRP_W]),
      .gp  (gp_w[gi]),
      .gg  (gg_w[gi])
    );
  end

  cla_block #(.N(N_GRP)) u_blk (.gp(gp_w), .gg(gg_w), .cin(cin_i), .gc(gc_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_o   <= '0;
      cout_o  <= 1'b0;
      c_msb_o <= 1'b0;
    end else begin
      sum_o   <= p_w ^ cbit_w;
      cout_o  <= gc_w[N_GRP];
      c_msb_o <= cbit_w[DW-1];
    end
  end

  // Lower-group arithmetic reference for the lookahead signals.
  logic [GRP_W:0] lo_sum_w;
  assign lo_sum_w = {1'b0, a_i[GRP_W-1:0]} + {1'b0, b_i[GRP_W-1:0]} + {{GRP_W{1'b0}}, cin_i};

  a_r4_group_prop: assert property (@(posedge clk) disable iff (rst)
    gp_w[0] |-> ((a_i[GRP_W-1:0] + b_i[GRP_W-1:0]) == {GRP_W{1'b1}}));

  a_r5_group_gen: assert property (@(posedge clk) disable iff (rst)
    gg_w[0] |-> gc_w[1]);

  a_r5_upper_cin: assert property (@(posedge clk) disable iff (rst)
    gc_w[1] == lo_sum_w[GRP_W]);

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (sum_o == '0 && !cout_o && !c_msb_o));

  a_r3_sum: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ({cout_o, sum_o} == ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} + {{DW{1'b0}}, $past(cin_i)})));

  a_r6_msb_carry: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (c_msb_o == (({1'b0, $past(a_i[DW-2:0])} + {1'b0, $past(b_i[DW-2:0])}
                          + {{(DW-1){1'b0}}, $past(cin_i)}) >> (DW-1)) != 0));
endmodule

// File: tb/cla2_adder_tb.sv
module cla2_adder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic       cin_i = 1'b0;
  logic [7:0] sum_o;
  logic       cout_o;
  logic       c_msb_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       cin;
  } item_t;

  item_t q[$];

  always #5 clk = ~clk;

  cla2_adder u_dut (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .cin_i(cin_i),
    .sum_o(sum_o), .cout_o(cout_o), .c_msb_o(c_msb_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Monitor: one item per clock, checked just after the capturing edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [8:0] full;
      logic [7:0] low7;
      logic [4:0] nib;
      it   = q.pop_front();
      full = {1'b0, it.a} + {1'b0, it.b} + {8'd0, it.cin};
      low7 = {1'b0, it.a[6:0]} + {1'b0, it.b[6:0]} + {7'd0, it.cin};
      nib  = {1'b0, it.a[3:0]} + {1'b0, it.b[3:0]};
      check({cout_o, sum_o} == full, "R3/R2 sum+carry", {cout_o, sum_o}, full);
      check(c_msb_o == low7[7], "R6 carry into msb", c_msb_o, low7[7]);
      if ((it.a[3:0] ^ it.b[3:0]) == 4'hF)
        check(sum_o[4] == (it.a[4] ^ it.b[4] ^ it.cin), "R4 nibble propagate",
              sum_o[4], it.a[4] ^ it.b[4] ^ it.cin);
      if (nib[4])
        check(sum_o[4] == (it.a[4] ^ it.b[4] ^ 1'b1), "R5 nibble generate",
              sum_o[4], it.a[4] ^ it.b[4] ^ 1'b1);
      if (it.a == 8'hFF && it.b == 8'h00 && it.cin)
        check(sum_o == 8'h00 && cout_o && c_msb_o, "R7 full propagate chain",
              {c_msb_o, cout_o, sum_o}, 10'h300);
    end
  end

  // Driver: exhaustive sweep, one combination per clock.
  initial begin
    a_i = 8'hA5; b_i = 8'h5A; cin_i = 1'b1;
    repeat (3) @(negedge clk);
    check(sum_o == 8'h00 && !cout_o && !c_msb_o, "R1 reset state", {c_msb_o, cout_o, sum_o}, 0);
    rst = 1'b0;
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        for (int c = 0; c < 2; c++) begin
          a_i = a[7:0]; b_i = b[7:0]; cin_i = c[0];
          q.push_back('{a: a[7:0], b: b[7:0], cin: c[0]});
          @(negedge clk);
        end
      end
    end
    // Reset again with live operands: outputs must clear.
    a_i = 8'hFF; b_i = 8'h01; cin_i = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sum_o == 8'h00 && !cout_o && !c_msb_o, "R1 reset mid-run", {c_msb_o, cout_o, sum_o}, 0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule